// File: doc/BRIEF.md
# Serial Program Memory Slice with On-Slice Program Counter

This block is one slice of a program store. Each slice holds 128 fixed words of 20 bits and carries its own 10-bit program counter. Eight slices, each strapped with a different slice number, share the same control, condition and jump-address wires. Together they form a 1024-word program memory. Every slice steps an identical copy of the counter. Only the slice whose number matches the upper three counter bits drives the shared serial line. The counters stay in step because they see the same commands.

Time is divided into operations. An operation lasts two word times, which is 40 bit clocks. In the first word time the current instruction word is shifted out one bit per clock, least significant bit first. A check bit goes out alongside the last data bit. The counter command present in the final bit time of an operation selects the address for the next operation. The command can hold, clear, step forward, step back, jump to an external address, or jump only when an external flag is set. This supports both sequential fetch and random access. The words are fixed constants that the slice computes from the global address.

Top module: `prog_rom_slice`

## Requirements
- R1: While reset is held and at the first clock after release, pc_o is 0, op_first_o is 1, and only the slice numbered 0 asserts sdata_oe_o.
- R2: An operation lasts 40 clocks and op_first_o is high in exactly its first clock. pc_o changes only at the clock edge that ends an operation. ctl_i, cond_i and jaddr_i are sampled at that edge.
- R3: ctl_i = 1 adds one to the counter, wrapping 1023 to 0. ctl_i = 2 subtracts one, wrapping 0 to 1023.
- R4: ctl_i = 3 clears the counter to 0. ctl_i = 0, 6 and 7 leave the counter unchanged.
- R5: ctl_i = 4 loads jaddr_i. ctl_i = 5 loads jaddr_i when cond_i is 1 and otherwise adds one.
- R6: In bit times 0 to 19 of an operation, a driving slice puts bit k of the word at pc_o on sdata_o during bit time k, least significant bit first.
- R7: sdata_oe_o is high only in bit times 0 to 19, and only when pc_o[9:7] equals the slice number. While it is low, sdata_o and parity_o are 0.
- R8: parity_o is 1 only in bit time 19 of a driving slice. Its value there makes the 20 word bits plus the parity bit hold an odd number of ones.
- R9: The word at global address A equals ((A*40503) XOR (A*1024) XOR 0xA5C3E) truncated to 20 bits.
- R10: Eight slices numbered 0 to 7 on common controls keep equal counters. In every bit time 0 to 19, exactly one of them drives the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset |
| ctl_i | input | 3 | Counter command for the next operation |
| cond_i | input | 1 | Flag for the conditional jump |
| jaddr_i | input | 10 | Jump target address |
| pc_o | output | 10 | Current program counter |
| op_first_o | output | 1 | High in the first bit time of each operation |
| sdata_o | output | 1 | Serial instruction bit, 0 when not driving |
| sdata_oe_o | output | 1 | This slice drives the serial line |
| parity_o | output | 1 | Odd check bit, valid in the last data bit time |

## Verification
The bench targets the counter wrap in both directions. A design that mishandles it lands in the wrong slice, and either no slice or two slices drive the line. The bench also crosses slice boundaries in both directions and jumps into all eight slices. This exposes a wrong select decode as a missing or duplicated serial word. The conditional jump is run with the flag low and with it high, so a design that ignores the flag shows a wrong next address. The unused command codes are applied to show they do not change the counter. Parity and bit order are compared against the computed word on every operation, so even parity, a reversed bit order or a mistimed parity bit all show as mismatches.

// File: rtl/prs_pkg.sv
package prs_pkg;

   // Counter commands; codes 6 and 7 act as hold.
   typedef enum logic [2:0] {
      PC_HOLD = 3'd0,
      PC_INC  = 3'd1,
      PC_DEC  = 3'd2,
      PC_CLR  = 3'd3,
      PC_LOAD = 3'd4,
      PC_CJMP = 3'd5
   } pc_op_e;

   // Fixed program content, computed from the global word address.
   function automatic logic [31:0] rom_mix(input int unsigned gaddr);
      logic [31:0] a;
      a = gaddr;
      rom_mix = (a * 32'd40503) ^ (a << 10) ^ 32'h000A_5C3E;
   endfunction

endpackage

// File: rtl/prs_op_timer.sv
module prs_op_timer #(
   parameter  int OP_LEN = 40,
   localparam int CW     = $clog2(OP_LEN)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [CW-1:0] bit_idx_o,
   output logic          op_first_o,
   output logic          op_end_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (op_end_o) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
   end

   assign bit_idx_o  = cnt_q;
   assign op_first_o = (cnt_q == '0);
   assign op_end_o   = (cnt_q == CW'(OP_LEN - 1));

   // R2
   op_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_end_o |=> op_first_o);

   // R2
   op_first_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_first_o |=> !op_first_o);

endmodule

// File: rtl/prs_pc.sv
module prs_pc
   import prs_pkg::*;
#(
   parameter int PC_W = 10,
   parameter int LA_W = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            op_end_i,
   input  logic [2:0]      ctl_i,
   input  logic            cond_i,
   input  logic [PC_W-1:0] jaddr_i,
   output logic [PC_W-1:0] pc_o,
   output logic [LA_W-1:0] fetch_la_o
);

   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] pc_nxt;
   logic [PC_W-1:0] pc_inc;

   assign pc_inc = pc_q + 1'b1;

   always_comb begin
      pc_nxt = pc_q;
      if (op_end_i) begin
         case (ctl_i)
            PC_INC:  pc_nxt = pc_inc;
            PC_DEC:  pc_nxt = pc_q - 1'b1;
            PC_CLR:  pc_nxt = '0;
            PC_LOAD: pc_nxt = jaddr_i;
            PC_CJMP: pc_nxt = cond_i ? jaddr_i : pc_inc;
            default: pc_nxt = pc_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= '0;
      else        pc_q <= pc_nxt;
   end

   assign pc_o       = pc_q;
   assign fetch_la_o = pc_nxt[LA_W-1:0];

   // R2
   pc_hold_mid_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_end_i |=> $stable(pc_q));

   // R3
   pc_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_end_i && ctl_i == PC_INC) |=> pc_q == PC_W'($past(pc_q) + 1'b1));

   // R3
   pc_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_end_i && ctl_i == PC_DEC) |=> pc_q == PC_W'($past(pc_q) - 1'b1));

   // R4
   pc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_end_i && ctl_i == PC_CLR) |=> pc_q == '0);

   // R5
   pc_jump_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_end_i && (ctl_i == PC_LOAD || (ctl_i == PC_CJMP && cond_i)))
      |=> pc_q == $past(jaddr_i));

   // R5
   pc_jump_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_end_i && ctl_i == PC_CJMP && !cond_i)
      |=> pc_q == PC_W'($past(pc_q) + 1'b1));

endmodule

// File: rtl/prs_store.sv
module prs_store
   import prs_pkg::*;
#(
   parameter  int WORD_W   = 20,
   parameter  int LA_W     = 7,
   parameter  int SLICE_ID = 0,
   localparam int DEPTH    = 1 << LA_W
) (
   input  logic [LA_W-1:0]   addr_i,
   output logic [WORD_W-1:0] word_o
);

   logic [WORD_W-1:0] mem [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      localparam int unsigned GADDR = SLICE_ID * DEPTH + i;
      assign mem[i] = WORD_W'(rom_mix(GADDR));
   end

   assign word_o = mem[addr_i];

endmodule

// File: rtl/prs_serial.sv
module prs_serial #(
   parameter  int WORD_W     = 20,
   parameter  int OP_LEN     = 40,
   parameter  bit ODD_PARITY = 1'b1,
   parameter  bit LSB_FIRST  = 1'b1,
   localparam int CW         = $clog2(OP_LEN),
   localparam int IW         = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              sel_i,
   input  logic [CW-1:0]     bit_idx_i,
   output logic              sdata_o,
   output logic              sdata_oe_o,
   output logic              parity_o
);

   logic [WORD_W-1:0] word_q;
   logic              par_q;
   logic              par_nxt;
   logic              in_win;
   logic              last_bit;
   logic [IW-1:0]     pos;

   if (ODD_PARITY) begin : g_odd
      assign par_nxt = ~^word_i;
   end else begin : g_even
      assign par_nxt = ^word_i;
   end

   // Loaded every clock while in reset, then once per operation.
   always_ff @(posedge clk) begin
      if (!rst_n || load_i) begin
         word_q <= word_i;
         par_q  <= par_nxt;
      end
   end

   if (LSB_FIRST) begin : g_lsb
      assign pos = IW'(bit_idx_i);
   end else begin : g_msb
      assign pos = IW'(WORD_W - 1) - IW'(bit_idx_i);
   end

   assign in_win     = (bit_idx_i < CW'(WORD_W));
   assign last_bit   = (bit_idx_i == CW'(WORD_W - 1));
   assign sdata_oe_o = sel_i && in_win;
   assign sdata_o    = sdata_oe_o && word_q[pos];
   assign parity_o   = sel_i && last_bit && par_q;

   // R7
   quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sdata_oe_o |-> (!sdata_o && !parity_o));

   // R8
   parity_last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      parity_o |-> (bit_idx_i == CW'(WORD_W - 1)));

   // R6
   word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(word_q));

endmodule

// File: rtl/prog_rom_slice.sv
module prog_rom_slice #(
   parameter  int WORD_W     = 20,
   parameter  int LOCAL_AW   = 7,
   parameter  int ID_W       = 3,
   parameter  int SLICE_ID   = 0,
   parameter  int OP_WORDS   = 2,
   parameter  bit ODD_PARITY = 1'b1,
   parameter  bit LSB_FIRST  = 1'b1,
   localparam int PC_W       = LOCAL_AW + ID_W,
   localparam int OP_LEN     = OP_WORDS * WORD_W,
   localparam int CW         = $clog2(OP_LEN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [2:0]      ctl_i,
   input  logic            cond_i,
   input  logic [PC_W-1:0] jaddr_i,
   output logic [PC_W-1:0] pc_o,
   output logic            op_first_o,
   output logic            sdata_o,
   output logic            sdata_oe_o,
   output logic            parity_o
);

   if (WORD_W < 2 || WORD_W > 32) begin : g_bad_word
      $error("prog_rom_slice: WORD_W must lie in 2..32");
   end
   if (ID_W < 1 || LOCAL_AW < 1) begin : g_bad_addr
      $error("prog_rom_slice: ID_W and LOCAL_AW must be at least 1");
   end
   if (SLICE_ID < 0 || SLICE_ID >= (1 << ID_W)) begin : g_bad_id
      $error("prog_rom_slice: SLICE_ID out of range for ID_W");
   end
   if (OP_WORDS < 2) begin : g_bad_op
      $error("prog_rom_slice: an operation needs at least two word times");
   end

   logic [CW-1:0]       bit_idx;
   logic                op_end;
   logic [LOCAL_AW-1:0] fetch_la;
   logic [WORD_W-1:0]   fetch_word;
   logic [PC_W-1:0]     pc;
   logic                sel;

   prs_op_timer #(.OP_LEN(OP_LEN)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_idx_o  (bit_idx),
      .op_first_o (op_first_o),
      .op_end_o   (op_end)
   );

   prs_pc #(.PC_W(PC_W), .LA_W(LOCAL_AW)) u_pc (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_end_i   (op_end),
      .ctl_i      (ctl_i),
      .cond_i     (cond_i),
      .jaddr_i    (jaddr_i),
      .pc_o       (pc),
      .fetch_la_o (fetch_la)
   );

   prs_store #(.WORD_W(WORD_W), .LA_W(LOCAL_AW), .SLICE_ID(SLICE_ID)) u_store (
      .addr_i (fetch_la),
      .word_o (fetch_word)
   );

   assign sel = (pc[PC_W-1 -: ID_W] == ID_W'(SLICE_ID));

   prs_serial #(
      .WORD_W     (WORD_W),
      .OP_LEN     (OP_LEN),
      .ODD_PARITY (ODD_PARITY),
      .LSB_FIRST  (LSB_FIRST)
   ) u_serial (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (op_end),
      .word_i     (fetch_word),
      .sel_i      (sel),
      .bit_idx_i  (bit_idx),
      .sdata_o    (sdata_o),
      .sdata_oe_o (sdata_oe_o),
      .parity_o   (parity_o)
   );

   assign pc_o = pc;

   // R10
   owner_only_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sdata_oe_o |-> (pc_o[PC_W-1 -: ID_W] == ID_W'(SLICE_ID)));

endmodule

// File: tb/prog_rom_slice_tb_top.sv
module prog_rom_slice_tb_top;

   localparam int W   = 20;
   localparam int PCW = 10;
   localparam int NS  = 8;
   localparam int OPL = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [2:0]     ctl = 3'd0;
   logic           cond = 1'b0;
   logic [PCW-1:0] jaddr = '0;

   logic [NS-1:0]  oe_v, sd_v, par_v, first_v;
   logic [PCW-1:0] pc_v [NS];

   for (genvar i = 0; i < NS; i++) begin : g_sl
      prog_rom_slice #(.SLICE_ID(i)) dut_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .ctl_i      (ctl),
         .cond_i     (cond),
         .jaddr_i    (jaddr),
         .pc_o       (pc_v[i]),
         .op_first_o (first_v[i]),
         .sdata_o    (sd_v[i]),
         .sdata_oe_o (oe_v[i]),
         .parity_o   (par_v[i])
      );
   end

   typedef struct {
      int        pc;
      logic [19:0] word;
      logic      par;
      int        tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   fails  = 0;
   int   pc_m   = 0;
   int   last_tag = 1;
   bit   done = 1'b0;

   function automatic string tname(input int t);
      case (t)
         1: return "R1";
         2: return "R2";
         3: return "R3";
         4: return "R4";
         5: return "R5";
         6: return "R6";
         7: return "R7";
         8: return "R8";
         9: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, expv);
      end
   endtask

   // R9: content rule computed from the global address
   function automatic logic [19:0] ref_word(input int a);
      int unsigned m;
      m = (a * 40503) ^ (a * 1024) ^ 32'h000A5C3E;
      return m[19:0];
   endfunction

   // Driver: called at the falling edge in bit time 0 of an operation.
   task automatic do_op(input logic [2:0] c, input logic cc, input int ja);
      exp_t e;
      e.pc   = pc_m;
      e.word = ref_word(pc_m);
      e.par  = ~^e.word;
      e.tag  = last_tag;
      q.push_back(e);
      ctl   = c;
      cond  = cc;
      jaddr = ja[PCW-1:0];
      repeat (OPL) @(negedge clk);
      case (c)
         3'd1: begin pc_m = (pc_m + 1) % 1024;    last_tag = 3; end
         3'd2: begin pc_m = (pc_m + 1023) % 1024; last_tag = 3; end
         3'd3: begin pc_m = 0;                    last_tag = 4; end
         3'd4: begin pc_m = ja;                   last_tag = 5; end
         3'd5: begin pc_m = cc ? ja : (pc_m + 1) % 1024; last_tag = 5; end
         default: last_tag = 4;
      endcase
   endtask

   // Monitor: rebuilds each serial word and compares it with the queue head.
   int          k = 0;
   int          pc_at0 = 0;
   logic [19:0] acc = '0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (first_v[0]) k = 0;
         else            k = k + 1;
         if (k == 0) pc_at0 = int'(pc_v[0]);
         if (k >= OPL) chk(1'b0, "R2", "missing op start", k, OPL - 1);
         if (k < W) begin
            // R10: exactly one slice drives
            chk($countones(oe_v) == 1, "R10", "drivers", $countones(oe_v), 1);
            acc[k] = |sd_v;
            if (k != W - 1)
               chk(par_v == '0, "R8", "parity early", int'(par_v), 0);
         end else begin
            // R7: nobody drives outside the word window
            chk(oe_v == '0 && sd_v == '0 && par_v == '0, "R7", "idle line",
                int'(oe_v | sd_v | par_v), 0);
         end
         if (k == W - 1) begin
            if (q.size() == 0) begin
               chk(1'b0, "R2", "unexpected word", 0, 1);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(int'(pc_v[0]) == e.pc, tname(e.tag), "pc", int'(pc_v[0]), e.pc);
               for (int i = 1; i < NS; i++)
                  chk(pc_v[i] == pc_v[0], "R10", "counters agree", int'(pc_v[i]), int'(pc_v[0]));
               // R6 and R9: serial word, LSB first
               chk(acc == e.word, "R6", "serial word", int'(acc), int'(e.word));
               // R8: odd parity on the last data bit
               chk((|par_v) == e.par, "R8", "parity", int'(|par_v), int'(e.par));
               // R7: the owning slice is the one enabled
               chk(oe_v[e.pc / 128], "R7", "owner", int'(oe_v), 1 << (e.pc / 128));
            end
         end
         if (k == OPL - 1)
            chk(int'(pc_v[0]) == pc_at0, "R2", "pc stable in op", int'(pc_v[0]), pc_at0);
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(pc_v[0] == '0, "R1", "reset pc", int'(pc_v[0]), 0);
      chk(first_v == '1, "R1", "reset op_first", int'(first_v), 8'hFF);
      chk(oe_v == 8'h01, "R1", "reset owner", int'(oe_v), 1);
      rst_n = 1'b1;
      chk(pc_v[0] == '0 && first_v[0], "R1", "first cycle", int'(pc_v[0]), 0);

      do_op(3'd1, 1'b0, 0);     // R3 -> 1
      do_op(3'd1, 1'b0, 0);     // -> 2
      do_op(3'd0, 1'b1, 555);   // R4 hold -> 2
      do_op(3'd6, 1'b1, 555);   // R4 unused code -> 2
      do_op(3'd7, 1'b0, 77);    // R4 unused code -> 2
      do_op(3'd2, 1'b0, 0);     // R3 -> 1
      do_op(3'd3, 1'b0, 0);     // R4 -> 0
      do_op(3'd2, 1'b0, 0);     // R3 wrap -> 1023
      do_op(3'd1, 1'b0, 0);     // R3 wrap -> 0
      do_op(3'd4, 1'b0, 130);   // R5 -> 130
      do_op(3'd5, 1'b0, 900);   // R5 not taken -> 131
      do_op(3'd5, 1'b1, 900);   // R5 taken -> 900
      do_op(3'd4, 1'b0, 127);   // -> 127
      do_op(3'd1, 1'b0, 0);     // slice boundary -> 128
      do_op(3'd2, 1'b0, 0);     // back -> 127
      for (int s = 0; s < NS; s++)
         do_op(3'd4, 1'b0, s * 128 + 37 + s);   // R10 visit each slice
      do_op(3'd4, 1'b0, 1023);
      do_op(3'd1, 1'b0, 0);     // -> 1023 then 0
      do_op(3'd0, 1'b0, 0);
      done = 1'b1;
      chk(q.size() == 0, "R2", "queue drained", q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R2 watchdog act=%0d exp=%0d", 100000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule